// File: doc/BRIEF.md
# Selectable-Source Serial Baud Generator

This block produces the bit-period timing that a serial port's transmitter and receiver share. It lives entirely in the system clock domain and emits a one-cycle baud tick once per bit period, plus a level that toggles on every tick for observation. No derived clocks are made; every divider advances on a clock enable.

The timing source is chosen by a two-bit select: the system clock itself, the system clock after a fixed divide-by-8 prescaler, or an external serial clock. The external clock is brought in through a two-flop synchronizer and its rising edges become single-cycle enables. A 16-bit divisor then divides the chosen source. In asynchronous mode a further divide-by-16 stage follows. In synchronous mode the divide-by-16 stage is skipped, and when the external source is selected in synchronous mode each external rising edge becomes a tick directly, whatever the divisor. A divisor of zero stops the ticks in every other case. A configuration write strobe restarts all dividers from zero so that the first period after a change has its full length.

Top module: `baud_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `baud_tick` and `baud_lvl` are 0.
- R2: Source encoding of `clk_sel`: bit 1 = 1 selects the external clock; with bit 1 = 0, bit 0 = 0 selects the system clock and bit 0 = 1 selects the system clock divided by 8.
- R3: With `sync_mode` = 0 and `divisor` = N > 0, one tick is produced every 16·N source events (system clock cycles, groups of 8 cycles, or external rising edges).
- R4: With `sync_mode` = 1, an internal source and `divisor` = N > 0, one tick is produced every N source events.
- R5: With `sync_mode` = 1 and the external source, one tick follows each external rising edge and `divisor` has no effect, including the value 0.
- R6: `divisor` = 0 produces no tick at all, except in the case of R5.
- R7: `divisor` = 1 passes the source events through the divisor stage undivided; in synchronous mode with the system clock the tick is high in every cycle.
- R8: A cycle with `cfg_wr` high restarts all dividers; the next cycle shows no tick, and for an internal source the first tick appears exactly one full period (counted in system clock cycles from the write edge) later.
- R9: `baud_tick` is high for one cycle per period (except the R7 every-cycle case), and `baud_lvl` changes value exactly in the cycles where `baud_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1 = synchronous mode, 0 = asynchronous mode |
| clk_sel | input | 2 | Source select, encoding in R2 |
| divisor | input | 16 | Divisor value N |
| cfg_wr | input | 1 | One-cycle strobe marking a configuration write; restarts dividers |
| ext_clk | input | 1 | External serial clock, asynchronous to `clk` |
| baud_tick | output | 1 | One-cycle baud enable |
| baud_lvl | output | 1 | Level toggled on every tick |

## Verification
The source and mode combinations are walked in a table that mixes divisors of 1, 2, 3, 5 and 7 across the system clock, the prescaled clock and the external clock, so a wrong factor of 8 or 16, a swapped select bit, or a divide-by-16 applied in the wrong mode each gives a different period. For internal sources the delay from the write strobe to the first tick is also compared, which separates a correct restart from one that keeps old counter state. Directed cases cover a zero divisor in both modes, a zero divisor that must be ignored in the external bypass, a write in the middle of a period, and the every-cycle tick of divisor 1.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned CD_W     = 16;
  localparam int unsigned PRE_DIV  = 8;
  localparam int unsigned OVS_DIV  = 16;
  localparam int unsigned SYNC_LEN = 2;

  typedef enum logic [1:0] {
    SRC_SYS  = 2'b00,
    SRC_SYS8 = 2'b01,
    SRC_EXT0 = 2'b10,
    SRC_EXT1 = 2'b11
  } src_sel_e;
endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel #(
  parameter int unsigned PRE_DIV  = baud_pkg::PRE_DIV,
  parameter int unsigned SYNC_LEN = baud_pkg::SYNC_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [1:0] clk_sel,
  input  logic       ext_clk,
  output logic       src_tick,
  output logic       ext_rise
);
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PW-1:0]     pre_cnt;
  logic              pre_tick;
  logic [SYNC_LEN:0] ext_sh;

  assign pre_tick = (pre_cnt == PW'(PRE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || pre_tick) pre_cnt <= '0;
    else                            pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ext_sh <= '0;
    else     ext_sh <= {ext_sh[SYNC_LEN-1:0], ext_clk};
  end

  assign ext_rise = ext_sh[SYNC_LEN-1] & ~ext_sh[SYNC_LEN];

  always_comb begin
    if (clk_sel[1])      src_tick = ext_rise;
    else if (clk_sel[0]) src_tick = pre_tick;
    else                 src_tick = 1'b1;
  end
endmodule

// File: rtl/baud_cd_div.sv
module baud_cd_div #(
  parameter int unsigned CD_W = baud_pkg::CD_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            in_tick,
  input  logic [CD_W-1:0] cd,
  output logic            out_tick
);
  logic [CD_W-1:0] cnt;
  logic            cd_big;
  logic            wrap;

  assign cd_big = (cd > CD_W'(1));
  assign wrap   = in_tick && (cnt >= cd - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart || !cd_big) cnt <= '0;
    else if (wrap)                 cnt <= '0;
    else if (in_tick)              cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (cd == CD_W'(1)) out_tick = in_tick;
    else if (cd_big)    out_tick = wrap;
    else                out_tick = 1'b0;
  end

  // R6
  zero_cd_chk: assert property (@(posedge clk) disable iff (rst)
    (cd == '0) |-> !out_tick);
endmodule

// File: rtl/baud_div16.sv
module baud_div16 #(
  parameter int unsigned OVS_DIV = baud_pkg::OVS_DIV
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic bypass,
  input  logic in_tick,
  output logic out_tick
);
  localparam int unsigned OW = $clog2(OVS_DIV);

  logic [OW-1:0] cnt;
  logic          last;

  assign last = (cnt == OW'(OVS_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || bypass) cnt <= '0;
    else if (in_tick)             cnt <= last ? '0 : cnt + 1'b1;
  end

  assign out_tick = bypass ? in_tick : (in_tick && last);
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned CD_W     = baud_pkg::CD_W,
  parameter int unsigned PRE_DIV  = baud_pkg::PRE_DIV,
  parameter int unsigned OVS_DIV  = baud_pkg::OVS_DIV,
  parameter int unsigned SYNC_LEN = baud_pkg::SYNC_LEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_mode,
  input  logic [1:0]      clk_sel,
  input  logic [CD_W-1:0] divisor,
  input  logic            cfg_wr,
  input  logic            ext_clk,
  output logic            baud_tick,
  output logic            baud_lvl
);
  logic src_tick, ext_rise, cd_tick, ovs_tick, stage_tick, ext_bypass;

  assign ext_bypass = sync_mode && clk_sel[1];

  baud_src_sel #(.PRE_DIV(PRE_DIV), .SYNC_LEN(SYNC_LEN)) i_src (
    .clk(clk), .rst(rst), .restart(cfg_wr), .clk_sel(clk_sel),
    .ext_clk(ext_clk), .src_tick(src_tick), .ext_rise(ext_rise));

  baud_cd_div #(.CD_W(CD_W)) i_cd (
    .clk(clk), .rst(rst), .restart(cfg_wr), .in_tick(src_tick),
    .cd(divisor), .out_tick(cd_tick));

  baud_div16 #(.OVS_DIV(OVS_DIV)) i_ovs (
    .clk(clk), .rst(rst), .restart(cfg_wr), .bypass(sync_mode),
    .in_tick(cd_tick), .out_tick(ovs_tick));

  assign stage_tick = ext_bypass ? ext_rise : ovs_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_tick <= 1'b0;
      baud_lvl  <= 1'b0;
    end else if (cfg_wr) begin
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= stage_tick;
      baud_lvl  <= baud_lvl ^ stage_tick;
    end
  end

  // R8
  wr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !baud_tick);

  // R9
  lvl_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    baud_tick == (baud_lvl != $past(baud_lvl)));

  // R3
  async_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (baud_tick && !sync_mode) |=> !baud_tick);

  // R6
  no_tick_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0 && !ext_bypass) |=> !baud_tick);
endmodule

// File: tb/test_baud_gen.sv
module test_baud_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_mode = 1'b0;
  logic [1:0]  clk_sel = 2'b00;
  logic [15:0] divisor = 16'd1;
  logic        cfg_wr = 1'b0;
  logic        ext_clk = 1'b0;
  logic        baud_tick, baud_lvl;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  baud_gen i_baud_gen (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .clk_sel(clk_sel),
    .divisor(divisor), .cfg_wr(cfg_wr), .ext_clk(ext_clk),
    .baud_tick(baud_tick), .baud_lvl(baud_lvl));

  // external clock: 3 cycles high, 3 low -> one rising edge per 6 cycles
  initial forever begin
    repeat (3) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  // fields: sync[35] sel[34:33] cd[32:17] period[16:1] check_first[0]
  localparam int NV = 9;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 2'b00, 16'd1, 16'd16,  1'b1},  // R3 R7 system clock
    {1'b0, 2'b00, 16'd3, 16'd48,  1'b1},  // R3
    {1'b0, 2'b01, 16'd2, 16'd256, 1'b1},  // R3 R2 prescaled
    {1'b1, 2'b00, 16'd5, 16'd5,   1'b1},  // R4
    {1'b1, 2'b01, 16'd3, 16'd24,  1'b1},  // R4 R2
    {1'b1, 2'b00, 16'd1, 16'd1,   1'b1},  // R4 R7
    {1'b1, 2'b10, 16'd7, 16'd6,   1'b0},  // R5 divisor ignored
    {1'b1, 2'b11, 16'd0, 16'd6,   1'b0},  // R5 zero ignored
    {1'b0, 2'b10, 16'd2, 16'd192, 1'b0}   // R3 R2 external
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic s, input logic [1:0] sel, input logic [15:0] cd);
    @(negedge clk);
    sync_mode = s; clk_sel = sel; divisor = cd; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // counts negedges until a tick is seen; returns -1 on timeout
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_tick && n < 2000);
    if (!baud_tick) n = -1;
  endtask

  initial begin
    int n, cnt;
    logic l0;
    string rq;
    repeat (3) @(negedge clk);
    check("R1 tick in reset", baud_tick, 0);
    check("R1 lvl in reset", baud_lvl, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tick after reset", baud_tick, 0);

    for (int i = 0; i < NV; i++) begin
      rq = VEC[i][35] ? (VEC[i][34] ? "R5" : "R4") : "R3";
      write_cfg(VEC[i][35], VEC[i][34:33], VEC[i][32:17]);
      check("R8 no tick after write", baud_tick, 0);
      wait_tick(n);
      if (VEC[i][0]) check({rq, " R8 first period"}, n, int'(VEC[i][16:1]));
      l0 = baud_lvl;
      wait_tick(n);
      check({rq, " period"}, n, int'(VEC[i][16:1]));
      check("R9 lvl toggles", int'(baud_lvl != l0), 1);
      if (VEC[i][16:1] > 16'd1) begin
        @(negedge clk);
        check("R9 tick one cycle wide", baud_tick, 0);
      end
    end

    // R6: zero divisor, asynchronous, system clock
    write_cfg(1'b0, 2'b00, 16'd0);
    cnt = 0;
    for (int k = 0; k < 400; k++) begin @(negedge clk); cnt += int'(baud_tick); end
    check("R6 async zero divisor", cnt, 0);

    // R6: zero divisor, synchronous, prescaled
    write_cfg(1'b1, 2'b01, 16'd0);
    cnt = 0;
    for (int k = 0; k < 400; k++) begin @(negedge clk); cnt += int'(baud_tick); end
    check("R6 sync zero divisor", cnt, 0);

    // R5: zero divisor ignored in external bypass
    write_cfg(1'b1, 2'b10, 16'd0);
    repeat (12) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); cnt += int'(baud_tick); end
    check("R5 ext ticks in 60 cycles", cnt, 10);

    // R7 and R9: every-cycle tick, level alternates
    write_cfg(1'b1, 2'b00, 16'd1);
    @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      l0 = baud_lvl;
      @(negedge clk);
      cnt += int'(baud_tick && (baud_lvl != l0));
    end
    check("R7 tick every cycle with lvl toggle", cnt, 10);

    // R8: write in the middle of a period restarts the count
    write_cfg(1'b1, 2'b00, 16'd10);
    repeat (4) @(negedge clk);
    write_cfg(1'b1, 2'b00, 16'd10);
    wait_tick(n);
    check("R8 mid-period restart", n, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule